// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a synchronous memory bus and a small byte array that behaves like a parallel NOR flash. Bus reads return array contents, a status byte, or identification and query data, depending on the command mode currently selected. Bus writes are treated as command cycles. A multi-cycle state machine decodes them and carries out word programming, sector erase, lock sequences and a counted buffered write. It also keeps an 8-bit status register whose error bits stay set until they are cleared.

Sector erase runs in hardware. A fill pointer walks the selected sector and writes 0xFF, one byte per clock. While the fill runs, `req_ready` is low and no access is accepted. In identification or query mode, the read data comes from an external responder: the block selects that responder through `aux_sel` and returns the value on `aux_rdata`. A secure strap can restrict non-secure masters to raw array reads only.

Top module: `nor_cmd_seq`

## Requirements
- R1: After synchronous reset the block is in array-read mode at write phase 0, the status byte is 0x80, every array byte is 0xFF, and `req_ready` is high.
- R2: An accepted read returns its data with `rsp_valid` one clock later. `req_size` 0/1/2(3) selects 1/2/4 bytes. In array mode with `strap_be` low, the byte at the lowest address goes to bits 7:0. With `strap_be` high, that byte goes to the most significant byte of the access. Unused upper bytes read as zero.
- R3: At phase 0, the write bytes 0x00, 0xF0 and 0xFF restore array-read mode. Any byte that is not a known command also restores array-read mode.
- R4: Byte 0x10 or 0x40 at phase 0, followed by a data write, stores that write into the array with the given width and endianness. It sets status bit 7 and returns to phase 0. Reads in between return the status byte.
- R5: While `strap_ro` is high, a program or buffered data write leaves the array unchanged and sets status bit 4 (0x10). An erase leaves the array unchanged and sets status bit 5 (0x20).
- R6: Byte 0x50 at phase 0 clears the whole status byte and restores array-read mode.
- R7: In status mode, entered with 0x70 or held by the program, erase, lock or buffered-write command, a read places the status byte in the low byte of every device-width lane inside the access width. All other bytes read as zero.
- R8: Byte 0x20 at phase 0 fills the sector that holds the address with 0xFF. `req_ready` stays low for exactly SECT_LEN clocks, and status bit 7 is set when the fill ends. Other sectors are untouched. At the next phase, 0xD0 completes the command; 0xFF or any other byte restores array-read mode.
- R9: After 0x60, a following 0xD0 or 0x01 sets status bit 7 and returns to phase 0 with status reads. Any other byte restores array-read mode.
- R10: After 0xE8, the next write loads a counter N from its low device-width bytes. N+1 data writes follow and are stored. Then 0xD0 completes the sequence and leaves status reads active. Any other byte at that point restores array-read mode, and the words already stored stay in the array.
- R11: Byte 0x90 sets `aux_sel` to 1 and 0x98 sets it to 2. Reads in these modes return `aux_rdata`. In query mode only 0xFF leaves the mode; other bytes keep it.
- R12: With `strap_secure` high and `req_secure` low, a read returns raw array data whatever the mode. A write has no effect and answers with `rsp_err` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write (command cycle), 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data; bits 7:0 carry the command byte |
| req_secure | input | 1 | Access is marked secure |
| strap_be | input | 1 | Big-endian data layout |
| strap_ro | input | 1 | Array is read-only |
| strap_secure | input | 1 | Restrict non-secure masters |
| req_ready | output | 1 | Request can be accepted (low during a sector fill) |
| rsp_valid | output | 1 | Response for the access accepted one clock earlier |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Write rejected by the secure strap |
| aux_sel | output | 2 | Responder select: 0 none, 1 identification, 2 query |
| aux_rdata | input | 32 | Data from the identification/query responder |

## Verification
The command machine is driven through complete sequences. These cover programming in both endiannesses, erase with confirm, with 0xFF and with a stray byte, lock with both completion bytes and with a bad one, and a counted buffered write that ends either in confirm or in abort. Each sequence shows whether the phase and the current command advance correctly. The same sequences are repeated with the read-only strap set, which separates the two sticky error bits from the ready bit and shows that the array stays unchanged. Secure and non-secure accesses are mixed while a non-array mode is active. This shows that the secure gate bypasses the mode for reads and blocks the state change for writes. Every read is compared against a behavioural model, and erase stall length is counted in clocks.

// File: rtl/nor_seq_pkg.sv
// Shared command codes, status bits, phase type and helpers for the
// NOR flash command sequencer. Assumes command bytes arrive in bits 7:0.
package nor_seq_pkg;

    localparam logic [7:0] OP_ARRAY   = 8'h00;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLRST   = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_STAT    = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_BUFWR   = 8'hE8;
    localparam logic [7:0] OP_ALTRST  = 8'hF0;
    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_UNLK    = 8'h01;

    localparam logic [7:0] ST_READY     = 8'h80;
    localparam logic [7:0] ST_ERASE_ERR = 8'h20;
    localparam logic [7:0] ST_PROG_ERR  = 8'h10;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARG     = 2'd1,
        PH_DATA    = 2'd2,
        PH_CONFIRM = 2'd3
    } phase_t;

    // Map the access width code onto a byte count.
    function automatic logic [2:0] size_to_nb(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // True for commands whose reads return the status byte.
    function automatic logic is_status_cmd(input logic [7:0] c);
        return (c == OP_PROG_A) || (c == OP_PROG_B) || (c == OP_ERASE) ||
               (c == OP_LOCK) || (c == OP_STAT) || (c == OP_BUFWR) ||
               (c == OP_CLRST);
    endfunction

endpackage

// File: rtl/nor_byte_array.sv
// Byte-addressed storage for the flash model. One data write port of 1..4
// bytes with selectable endianness, one fill port that writes 0xFF, and a
// combinational read port. Assumes the fill and data ports are never
// active together. Reset puts the array into the erased state.
module nor_byte_array #(
    parameter int NBYTES = 256,
    parameter int AW     = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [2:0]    wr_nb,
    input  logic [31:0]   wr_data,
    input  logic          big_end,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_addr,
    input  logic [AW-1:0] rd_addr,
    input  logic [2:0]    rd_nb,
    output logic [31:0]   rd_word
);
    logic [7:0]    mem [NBYTES];
    logic [AW-1:0] wa  [4];
    logic [7:0]    wv  [4];
    logic [3:0]    wen;

    // Per-byte write address, value and enable; packed read word.
    always_comb begin
        int lane;
        rd_word = '0;
        for (int k = 0; k < 4; k++) begin
            wa[k]  = wr_addr + AW'(k);
            lane   = big_end ? (int'(wr_nb) - 1 - k) : k;
            if (lane < 0) lane = 0;
            wv[k]  = wr_data[8*lane +: 8];
            wen[k] = wr_en && (k < int'(wr_nb));
        end
        for (int k = 0; k < 4; k++) begin
            if (k < int'(rd_nb)) begin
                lane = big_end ? (int'(rd_nb) - 1 - k) : k;
                rd_word[8*lane +: 8] = mem[rd_addr + AW'(k)];
            end
        end
    end

    // Storage update: erased on reset, then fill and data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NBYTES; k++) mem[k] <= 8'hFF;
        end else begin
            if (fill_en) mem[fill_addr] <= 8'hFF;
            for (int k = 0; k < 4; k++) begin
                if (wen[k]) mem[wa[k]] <= wv[k];
            end
        end
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
// Command-cycle state machine: write phase, current command, status byte,
// buffered-write counter and the sector fill walker. Assumes wr_acc is
// only raised for accepted, permitted writes, and that SECT_LEN is a
// power of two.
module nor_cmd_fsm
    import nor_seq_pkg::*;
#(
    parameter int SECT_LEN = 64,
    parameter int AW       = 8,
    parameter int DEV_W    = 1,
    localparam int CW      = 8 * DEV_W,
    localparam int SW      = $clog2(SECT_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_acc,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_arg,
    input  logic          ro,
    output logic [7:0]    cmd_o,
    output logic [7:0]    status_o,
    output logic          busy_o,
    output logic          prog_we,
    output logic          fill_we,
    output logic [AW-1:0] fill_addr
);
    logic [7:0]    cmd_q, cmd_n;
    logic [7:0]    status_q, status_n;
    phase_t        phase_q, phase_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          busy_q, start_fill;
    logic [AW-1:0] fill_ptr;
    logic [SW:0]   fill_left;
    logic [7:0]    op;
    logic          is_prog;

    assign op      = wr_arg[7:0];
    assign is_prog = (cmd_q == OP_PROG_A) || (cmd_q == OP_PROG_B);

    // Array write strobe for program and buffered data cycles.
    assign prog_we = wr_acc && !ro &&
                     ((phase_q == PH_ARG && is_prog) ||
                      (phase_q == PH_DATA && cmd_q == OP_BUFWR));

    // Next-state decode of one command cycle.
    always_comb begin
        cmd_n      = cmd_q;
        status_n   = status_q;
        phase_n    = phase_q;
        cnt_n      = cnt_q;
        start_fill = 1'b0;
        if (busy_q && fill_left == (SW+1)'(1)) status_n = status_n | ST_READY;
        if (wr_acc) begin
            case (phase_q)
                PH_IDLE: begin
                    case (op)
                        OP_CLRST: begin
                            status_n = '0;
                            cmd_n    = OP_ARRAY;
                        end
                        OP_STAT, OP_IDENT: cmd_n = op;
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            cmd_n   = op;
                            phase_n = PH_ARG;
                        end
                        OP_ERASE: begin
                            cmd_n   = op;
                            phase_n = PH_ARG;
                            if (ro) status_n = status_n | ST_ERASE_ERR | ST_READY;
                            else    start_fill = 1'b1;
                        end
                        OP_BUFWR: begin
                            cmd_n    = op;
                            phase_n  = PH_ARG;
                            status_n = status_n | ST_READY;
                        end
                        default: cmd_n = OP_ARRAY;
                    endcase
                end
                PH_ARG: begin
                    phase_n = PH_IDLE;
                    if (is_prog) begin
                        status_n = status_n | ST_READY | (ro ? ST_PROG_ERR : 8'h00);
                    end else if (cmd_q == OP_ERASE) begin
                        if (op == OP_CONFIRM) status_n = status_n | ST_READY;
                        else                  cmd_n = OP_ARRAY;
                    end else if (cmd_q == OP_LOCK) begin
                        if (op == OP_CONFIRM || op == OP_UNLK) status_n = status_n | ST_READY;
                        else                                    cmd_n = OP_ARRAY;
                    end else if (cmd_q == OP_QUERY) begin
                        if (op == OP_RESET) cmd_n = OP_ARRAY;
                        else                phase_n = PH_ARG;
                    end else if (cmd_q == OP_BUFWR) begin
                        cnt_n   = wr_arg;
                        phase_n = PH_DATA;
                    end else begin
                        cmd_n = OP_ARRAY;
                    end
                end
                PH_DATA: begin
                    if (cmd_q == OP_BUFWR) begin
                        status_n = status_n | ST_READY | (ro ? ST_PROG_ERR : 8'h00);
                        if (cnt_q == '0) phase_n = PH_CONFIRM;
                        cnt_n = cnt_q - CW'(1);
                    end else begin
                        cmd_n   = OP_ARRAY;
                        phase_n = PH_IDLE;
                    end
                end
                default: begin
                    phase_n = PH_IDLE;
                    if (cmd_q == OP_BUFWR && op == OP_CONFIRM) status_n = status_n | ST_READY;
                    else                                       cmd_n = OP_ARRAY;
                end
            endcase
        end
    end

    // State registers and the byte-per-clock sector fill walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= OP_ARRAY;
            status_q  <= ST_READY;
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            busy_q    <= 1'b0;
            fill_ptr  <= '0;
            fill_left <= '0;
        end else begin
            cmd_q    <= cmd_n;
            status_q <= status_n;
            phase_q  <= phase_n;
            cnt_q    <= cnt_n;
            if (start_fill) begin
                busy_q    <= 1'b1;
                fill_ptr  <= wr_addr & ~AW'(SECT_LEN - 1);
                fill_left <= (SW+1)'(SECT_LEN);
            end else if (busy_q) begin
                fill_ptr  <= fill_ptr + AW'(1);
                fill_left <= fill_left - (SW+1)'(1);
                if (fill_left == (SW+1)'(1)) busy_q <= 1'b0;
            end
        end
    end

    assign cmd_o     = cmd_q;
    assign status_o  = status_q;
    assign busy_o    = busy_q;
    assign fill_we   = busy_q;
    assign fill_addr = fill_ptr;

    a_r8_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !wr_acc);

    a_r8_ready_at_fill_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> status_q[7]);

    a_r4_program_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && phase_q == PH_ARG && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
        |=> (status_q[7] && phase_q == PH_IDLE));

    a_r10_confirm_after_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CONFIRM && $past(phase_q) != PH_CONFIRM)
        |-> ($past(phase_q) == PH_DATA && $past(cnt_q) == '0));
endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR flash command sequencer: bus accept, secure gating, read
// data selection by mode and a one-cycle registered response. Assumes
// accesses are aligned to their width and that identification and query
// data come from an external responder on aux_rdata.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int SECT_LEN = 64,
    parameter int NSECT    = 4,
    parameter int DEV_W    = 1,
    parameter int AW       = $clog2(SECT_LEN * NSECT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic [31:0]   req_wdata,
    input  logic          req_secure,
    input  logic          strap_be,
    input  logic          strap_ro,
    input  logic          strap_secure,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err,
    output logic [1:0]    aux_sel,
    input  logic [31:0]   aux_rdata
);
    localparam int NBYTES = SECT_LEN * NSECT;
    localparam int CW     = 8 * DEV_W;

    logic          acc, blocked, wr_acc, busy, prog_we, fill_we;
    logic [2:0]    nb;
    logic [7:0]    cmd, status;
    logic [AW-1:0] fill_addr;
    logic [31:0]   arr_word, stat_word, rd_mux;

    assign acc       = req_valid && req_ready;
    assign blocked   = strap_secure && !req_secure;
    assign wr_acc    = acc && req_we && !blocked;
    assign nb        = size_to_nb(req_size);
    assign req_ready = !busy;

    nor_cmd_fsm #(.SECT_LEN(SECT_LEN), .AW(AW), .DEV_W(DEV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_acc    (wr_acc),
        .wr_addr   (req_addr),
        .wr_arg    (req_wdata[CW-1:0]),
        .ro        (strap_ro),
        .cmd_o     (cmd),
        .status_o  (status),
        .busy_o    (busy),
        .prog_we   (prog_we),
        .fill_we   (fill_we),
        .fill_addr (fill_addr)
    );

    nor_byte_array #(.NBYTES(NBYTES), .AW(AW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prog_we),
        .wr_addr   (req_addr),
        .wr_nb     (nb),
        .wr_data   (req_wdata),
        .big_end   (strap_be),
        .fill_en   (fill_we),
        .fill_addr (fill_addr),
        .rd_addr   (req_addr),
        .rd_nb     (nb),
        .rd_word   (arr_word)
    );

    // Status byte placed in the low byte of each device-width lane.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        if ((g % DEV_W) == 0) begin : g_hit
            assign stat_word[8*g +: 8] = (3'(g) < nb) ? status : 8'h00;
        end else begin : g_miss
            assign stat_word[8*g +: 8] = 8'h00;
        end
    end

    // Responder select follows the current command.
    always_comb begin
        if (cmd == OP_IDENT)      aux_sel = 2'd1;
        else if (cmd == OP_QUERY) aux_sel = 2'd2;
        else                      aux_sel = 2'd0;
    end

    // Read source: raw array for gated masters, otherwise by mode.
    always_comb begin
        if (blocked || cmd == OP_ARRAY) rd_mux = arr_word;
        else if (is_status_cmd(cmd))    rd_mux = stat_word;
        else if (aux_sel != 2'd0)       rd_mux = aux_rdata;
        else                            rd_mux = arr_word;
    end

    // One-cycle registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc;
            rsp_err   <= acc && req_we && blocked;
            rsp_rdata <= (acc && !req_we) ? rd_mux : 32'h0;
        end
    end

    a_r12_reject_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we && strap_secure && !req_secure)
        |=> (rsp_valid && rsp_err));
endmodule

// File: tb/test_nor_cmd_seq.sv
// Self-checking bench with a behavioural reference model of the sequencer.
module test_nor_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SECT = 64;
    localparam int NS   = 4;
    localparam int NB   = SECT * NS;
    localparam int DW   = 1;
    localparam int AWB  = $clog2(NB);

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_we = 0, req_secure = 0;
    logic [AWB-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic strap_be = 0, strap_ro = 0, strap_secure = 0;
    logic req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata, aux_rdata;
    logic [1:0] aux_sel;

    assign aux_rdata = 32'h5A00_0000 | {30'd0, aux_sel};

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq i_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .strap_be(strap_be), .strap_ro(strap_ro),
        .strap_secure(strap_secure), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .aux_sel(aux_sel),
        .aux_rdata(aux_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] mm [NB];
    logic [7:0] m_st;
    int m_cmd, m_ph, m_cnt;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic bit stat_cmd(input int c);
        return c == 'h10 || c == 'h40 || c == 'h20 || c == 'h60 || c == 'h70 || c == 'hE8;
    endfunction

    function automatic logic [31:0] exp_read(input int a, input int sz, input bit sec);
        int n = nbytes(sz);
        logic [31:0] w = '0;
        if ((strap_secure && !sec) || m_cmd == 0) begin
            for (int i = 0; i < n; i++) begin
                int lane = strap_be ? (n - 1 - i) : i;
                w[8*lane +: 8] = mm[(a + i) % NB];
            end
        end else if (stat_cmd(m_cmd)) begin
            for (int i = 0; i < n; i++) if (i % DW == 0) w[8*i +: 8] = m_st;
        end else if (m_cmd == 'h90) w = 32'h5A00_0001;
        else if (m_cmd == 'h98) w = 32'h5A00_0002;
        return w;
    endfunction

    task automatic store(input int a, input logic [31:0] d, input int sz);
        int n = nbytes(sz);
        for (int i = 0; i < n; i++) begin
            int lane = strap_be ? (n - 1 - i) : i;
            mm[(a + i) % NB] = d[8*lane +: 8];
        end
    endtask

    task automatic to_array();
        m_cmd = 0;
        m_ph  = 0;
    endtask

    task automatic mdl_write(input int a, input logic [31:0] d, input int sz, output int busy);
        int op = int'(d[7:0]);
        int mask = (1 << (8*DW)) - 1;
        busy = 0;
        case (m_ph)
            0: begin
                if (op == 'h50) begin m_st = 8'h00; to_array(); end
                else if (op == 'h70 || op == 'h90) m_cmd = op;
                else if (op == 'h10 || op == 'h40 || op == 'h60 || op == 'h98) begin m_cmd = op; m_ph = 1; end
                else if (op == 'h20) begin
                    m_cmd = op; m_ph = 1;
                    if (strap_ro) m_st = m_st | 8'hA0;
                    else begin
                        int base = (a / SECT) * SECT;
                        for (int i = 0; i < SECT; i++) mm[base + i] = 8'hFF;
                        m_st = m_st | 8'h80;
                        busy = SECT;
                    end
                end else if (op == 'hE8) begin m_cmd = op; m_ph = 1; m_st = m_st | 8'h80; end
                else to_array();
            end
            1: begin
                if (m_cmd == 'h10 || m_cmd == 'h40) begin
                    if (!strap_ro) store(a, d, sz); else m_st = m_st | 8'h10;
                    m_st = m_st | 8'h80; m_ph = 0;
                end else if (m_cmd == 'h20) begin
                    if (op == 'hD0) begin m_ph = 0; m_st = m_st | 8'h80; end else to_array();
                end else if (m_cmd == 'h60) begin
                    if (op == 'hD0 || op == 'h01) begin m_ph = 0; m_st = m_st | 8'h80; end else to_array();
                end else if (m_cmd == 'h98) begin
                    if (op == 'hFF) to_array();
                end else begin
                    m_cnt = int'(d) & mask; m_ph = 2;
                end
            end
            2: begin
                if (!strap_ro) store(a, d, sz); else m_st = m_st | 8'h10;
                m_st = m_st | 8'h80;
                if (m_cnt == 0) m_ph = 3;
                m_cnt = (m_cnt - 1) & mask;
            end
            default: begin
                if (op == 'hD0) begin m_ph = 0; m_st = m_st | 8'h80; end else to_array();
            end
        endcase
    endtask

    task automatic xfer(input bit we, input int a, input int sz, input logic [31:0] d,
                        input bit sec, input string tag);
        logic [31:0] exp_rd;
        bit exp_err, gated;
        int exp_busy = 0, n = 0;
        @(negedge clk);
        gated   = strap_secure && !sec;
        exp_rd  = exp_read(a, sz, sec);
        exp_err = we && gated;
        if (we && !gated) mdl_write(a, d, sz, exp_busy);
        req_valid = 1; req_we = we; req_addr = AWB'(a); req_size = 2'(sz);
        req_wdata = d; req_secure = sec;
        @(negedge clk);
        req_valid = 0; req_we = 0;
        chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_err === exp_err, {tag, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
        if (!we) chk(rsp_rdata === exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
        while (req_ready !== 1'b1 && n < 10 * SECT) begin
            n++;
            @(negedge clk);
        end
        if (exp_busy > 0 || n > 0) chk(n == exp_busy, "R8 stall clocks", 32'(n), 32'(exp_busy));
    endtask

    task automatic wr(input int a, input logic [31:0] d, input int sz, input string tag);
        xfer(1'b1, a, sz, d, 1'b0, tag);
    endtask

    task automatic rd(input int a, input int sz, input string tag);
        xfer(1'b0, a, sz, 32'h0, 1'b0, tag);
    endtask

    initial begin
        for (int i = 0; i < NB; i++) mm[i] = 8'hFF;
        m_st = 8'h80; m_cmd = 0; m_ph = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid === 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        chk(aux_sel === 2'd0, "R1 aux_sel after reset", 32'(aux_sel), 32'd0);
        rd(8'h00, 2, "R1 erased array");
        wr(0, 32'h70, 0, "R1 enter status");
        rd(0, 0, "R1 status 0x80");
        wr(0, 32'hFF, 0, "R3 reset cmd");

        // R4 / R2: little-endian program and read-back at all widths
        wr(0, 32'h40, 0, "R4 program cmd");
        rd(0, 2, "R7 status in program mode");
        wr(8'h10, 32'h1122_3344, 2, "R4 program word");
        rd(8'h10, 2, "R4 status after program");
        wr(0, 32'hF0, 0, "R3 alt reset");
        rd(8'h10, 2, "R2 LE word");
        rd(8'h11, 0, "R2 byte read");
        rd(8'h12, 1, "R2 LE half");
        // big-endian program
        strap_be = 1;
        wr(0, 32'h10, 0, "R4 program cmd b");
        wr(8'h20, 32'h0000_AABB, 1, "R4 BE half");
        wr(0, 32'h00, 0, "R3 zero cmd");
        rd(8'h20, 0, "R2 BE first byte");
        rd(8'h20, 1, "R2 BE half");
        rd(8'h10, 2, "R2 BE word");
        strap_be = 0;
        rd(8'h20, 1, "R2 LE view of BE data");

        // R3: unknown byte returns to array mode
        wr(0, 32'h70, 0, "R3 status");
        wr(0, 32'h33, 0, "R3 unknown");
        rd(8'h10, 2, "R3 array after unknown");

        // R5 / R6: read-only errors then clear
        strap_ro = 1;
        wr(0, 32'h40, 0, "R5 program ro");
        wr(8'h10, 32'hDEAD_BEEF, 2, "R5 data ro");
        rd(0, 0, "R5 prog error bit");
        wr(8'h40, 32'h20, 0, "R5 erase ro");
        wr(8'h40, 32'hD0, 0, "R5 erase confirm");
        rd(0, 0, "R5 erase error bit");
        wr(0, 32'hFF, 0, "R5 back to array");
        rd(8'h10, 2, "R5 array unchanged");
        strap_ro = 0;
        wr(0, 32'h50, 0, "R6 clear");
        rd(8'h10, 2, "R6 array mode after clear");
        wr(0, 32'h70, 0, "R6 status");
        rd(0, 2, "R6 status cleared");
        wr(0, 32'hFF, 0, "R6 exit");

        // R8: sector erase leaves other sectors intact
        wr(0, 32'h40, 0, "R8 prep");
        wr(8'h44, 32'h77, 0, "R8 prep data");
        wr(8'h25, 32'h20, 0, "R8 erase sector0");
        rd(0, 0, "R8 status after fill");
        wr(8'h25, 32'hD0, 0, "R8 confirm");
        rd(0, 1, "R8 status half");
        wr(0, 32'hFF, 0, "R8 exit");
        rd(8'h10, 2, "R8 sector erased");
        rd(8'h44, 0, "R8 other sector kept");
        wr(8'h44, 32'h20, 0, "R8 erase sector1");
        wr(8'h44, 32'hFF, 0, "R8 ff at arg");
        rd(8'h44, 0, "R8 array after ff");
        wr(8'h80, 32'h20, 0, "R8 erase sector2");
        wr(8'h80, 32'h33, 0, "R8 stray at arg");
        rd(8'h80, 2, "R8 array after stray");

        // R9: lock sequences
        wr(0, 32'h50, 0, "R9 clear");
        wr(0, 32'h60, 0, "R9 lock");
        wr(0, 32'h01, 0, "R9 unlock byte");
        rd(0, 0, "R9 ready after 01");
        wr(0, 32'h60, 0, "R9 lock b");
        wr(0, 32'hD0, 0, "R9 confirm");
        rd(0, 0, "R9 ready after d0");
        wr(0, 32'h60, 0, "R9 lock c");
        wr(0, 32'h42, 0, "R9 bad byte");
        rd(8'h44, 0, "R9 array after bad");

        // R10: buffered write with confirm, then aborted one
        wr(8'h80, 32'hE8, 0, "R10 start");
        wr(8'h80, 32'h0000_0302, 0, "R10 count 2");
        wr(8'h80, 32'hA1A2_A3A4, 2, "R10 word0");
        wr(8'h84, 32'hB1B2_B3B4, 2, "R10 word1");
        wr(8'h88, 32'hC1C2_C3C4, 2, "R10 word2");
        wr(0, 32'hD0, 0, "R10 confirm");
        rd(0, 0, "R10 status after confirm");
        wr(0, 32'hFF, 0, "R10 exit");
        rd(8'h80, 2, "R10 word0 back");
        rd(8'h84, 2, "R10 word1 back");
        rd(8'h88, 2, "R10 word2 back");
        rd(8'h8C, 2, "R10 no overrun");
        wr(8'hC0, 32'hE8, 0, "R10 start b");
        wr(8'hC0, 32'h00, 0, "R10 count 0");
        wr(8'hC0, 32'h5A, 0, "R10 single word");
        wr(8'hC0, 32'h77, 0, "R10 abort");
        rd(8'hC0, 0, "R10 array after abort");

        // R11: identification and query modes
        wr(0, 32'h90, 0, "R11 ident");
        rd(0, 2, "R11 ident data");
        wr(0, 32'h98, 0, "R11 query");
        rd(8'h10, 2, "R11 query data");
        wr(0, 32'h12, 0, "R11 stay query");
        rd(8'h20, 0, "R11 still query");
        wr(0, 32'hFF, 0, "R11 leave query");
        rd(8'h80, 2, "R11 array again");

        // R12: secure gating
        strap_secure = 1;
        xfer(1'b1, 0, 0, 32'h70, 1'b0, "R12 gated write");
        rd(8'h84, 2, "R12 state unchanged");
        xfer(1'b1, 0, 0, 32'h70, 1'b1, "R12 secure write");
        xfer(1'b0, 0, 0, 32'h0, 1'b1, "R12 secure status");
        xfer(1'b0, 8'h84, 2, 32'h0, 1'b0, "R12 raw array");
        strap_secure = 0;
        rd(0, 2, "R7 status wide");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule